// File: doc/BRIEF.md
# AXI Read Issue Credit Gate

This block sits between a processor's read requesters and the read address channel of an AXI master port. Three request sources compete for the channel: data cache linefills, non-cacheable data reads, and instruction fetches or instruction linefills. Each source draws on a pool of credits with its own outstanding limit. A credit is taken when the address handshake completes. It is returned when the final data beat of that read is accepted (RLAST high). The pool is chosen by the read ID on the returning beat.

The write side of the same port raises a saturation flag when every write slot is in use. While that flag is high, both data sources are held off. An instruction fetch may still go out, so the port as a whole never has more than the write maximum plus one instruction read in flight.

A parameter selects one of two modes. In the high-throughput mode, linefills and non-cacheable reads have separate pools of 2 and 4. In the compact mode, both data sources share one pool of 4. The instruction pool holds 1 in either mode. The selected mode must match the one chosen for the write tracker. Deassertion of `rst_n` is expected to arrive already synchronised to `clk`.

Top module: `axi_rd_credit_gate`

## Requirements
- R1: While reset is applied and on the first cycle after it, `m_arvalid` and every bit of `req_gnt` are low. All credit pools start empty.
- R2: In high-throughput mode, linefill requests (`req_vld` bit 0) are issued with ID 0, and no more than 2 of them are ever outstanding.
- R3: In high-throughput mode, non-cacheable data requests (`req_vld` bit 1) are issued with ID 1, and no more than 4 of them are ever outstanding.
- R4: Instruction requests (`req_vld` bit 2) are limited to 1 outstanding. They are issued with ID 2 in high-throughput mode and ID 1 in compact mode.
- R5: In compact mode, linefill and non-cacheable requests share one pool of 4 and are both issued with ID 0. Total outstanding reads never exceed 7 in high-throughput mode or 5 in compact mode.
- R6: While `wr_sat` is high, no data request (bit 0 or 1) is granted, and an instruction request with a free credit is still granted.
- R7: At most one grant is given per cycle. Among eligible requests, the order is instruction, then linefill, then non-cacheable.
- R8: A credit is returned only on a cycle with `m_rvalid`, `m_rready` and `m_rlast` all high, to the pool named by `m_rid`. Beats without RLAST are ignored. In high-throughput mode ID 3 is ignored; in compact mode IDs 2 and 3 are ignored.
- R9: A grant is given only when the address register is empty. The granted address and ID appear on `m_arvalid`/`m_araddr`/`m_arid` in the next cycle and hold unchanged until `m_arready`.
- R10: An address handshake and a credit return on the same pool in the same cycle leave that pool's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_sat | input | 1 | Write tracker reports all write slots in use |
| req_vld | input | 3 | Request valid per source: bit 0 linefill, bit 1 non-cacheable, bit 2 instruction |
| req_addr | input | 3*ADDR_W | Request address per source, source k in slice k |
| req_gnt | output | 3 | One-hot grant; the source's request is taken this cycle |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_arid | output | ID_W | Read address ID |
| m_araddr | output | ADDR_W | Read address |
| m_rvalid | input | 1 | Read data valid (observed) |
| m_rready | input | 1 | Read data ready (observed) |
| m_rid | input | ID_W | Read data ID (observed) |
| m_rlast | input | 1 | Last beat of a read burst (observed) |

## Verification
The bench drives each pool to its limit with responses held off, then returns credits in random order mixed with non-final beats and unused IDs. A design that retired credits on every beat, or on the spare ID, would grant past the limit; the per-cycle comparison with the reference model shows this as an unexpected grant. Saturation phases keep `wr_sat` high while all three sources request. A design that also blocked instructions, or let data through, would show a missing or extra grant. Slow `m_arready` phases check that the address and ID stay unchanged while stalled. Both modes run side by side, which exposes a compact-mode design that kept separate data pools, since that design would allow more than 4 data reads.

// File: rtl/axi_rd_credit_pkg.sv
`timescale 1ns/1ps
package axi_rd_credit_pkg;

  localparam int NKIND    = 3;
  localparam int K_LINE   = 0;
  localparam int K_NCRD   = 1;
  localparam int K_IFETCH = 2;

  // Request source to credit pool; the pool index is also the AXI ID.
  function automatic int kind_pool(input bit hp, input int k);
    if (hp) return k;
    return (k == K_IFETCH) ? 1 : 0;
  endfunction

  function automatic int pool_count(input bit hp);
    return hp ? 3 : 2;
  endfunction

endpackage

// File: rtl/rd_credit_ctr.sv
`timescale 1ns/1ps
module rd_credit_ctr #(
  parameter int CAP   = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             room
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc ^ dec;
    cnt_d  = cnt;
    if (inc && !dec)      cnt_d = cnt + 1'b1;
    else if (dec && !inc) cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign room = (cnt < CAP_V);

  // R2
  cap_never_exceeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP_V);

  // R2
  issue_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |-> room);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt != '0));

  // R10
  inc_dec_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));

endmodule

// File: rtl/rd_kind_arb.sv
`timescale 1ns/1ps
module rd_kind_arb import axi_rd_credit_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_free,
  input  logic             wr_sat,
  input  logic [NKIND-1:0] req_vld,
  input  logic [NKIND-1:0] kind_room,
  output logic [NKIND-1:0] gnt
);
  logic [NKIND-1:0] elig;

  always_comb begin
    elig = req_vld & kind_room;
    if (wr_sat) begin
      elig[K_LINE] = 1'b0;
      elig[K_NCRD] = 1'b0;
    end
    gnt = '0;
    if (slot_free) begin
      if (elig[K_IFETCH])    gnt[K_IFETCH] = 1'b1;
      else if (elig[K_LINE]) gnt[K_LINE]   = 1'b1;
      else if (elig[K_NCRD]) gnt[K_NCRD]   = 1'b1;
    end
  end

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R6
  data_held_on_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sat |-> (!gnt[K_LINE] && !gnt[K_NCRD]));

  // R9
  grant_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> slot_free);

endmodule

// File: rtl/rd_ar_slot.sv
`timescale 1ns/1ps
module rd_ar_slot #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ID_W-1:0]   load_id,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              arready,
  output logic              arvalid,
  output logic [ID_W-1:0]   arid,
  output logic [ADDR_W-1:0] araddr,
  output logic              hs,
  output logic              free
);
  logic vld_d;

  always_comb begin
    hs    = arvalid && arready;
    free  = !arvalid;
    vld_d = load || (arvalid && !arready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arvalid <= 1'b0;
    else        arvalid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arid   <= '0;
      araddr <= '0;
    end else if (load) begin
      arid   <= load_id;
      araddr <= load_addr;
    end
  end

  // R9
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(arid) && $stable(araddr)));

  // R9
  load_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !arvalid);

endmodule

// File: rtl/rd_retire_map.sv
`timescale 1ns/1ps
module rd_retire_map #(
  parameter int NPOOL = 3,
  parameter int ID_W  = 2
) (
  input  logic             rvalid,
  input  logic             rready,
  input  logic             rlast,
  input  logic [ID_W-1:0]  rid,
  output logic [NPOOL-1:0] dec
);
  logic fin;
  assign fin = rvalid && rready && rlast;

  for (genvar p = 0; p < NPOOL; p++) begin : g_dec
    assign dec[p] = fin && (rid == ID_W'(p));
  end

endmodule

// File: rtl/axi_rd_credit_gate.sv
`timescale 1ns/1ps
module axi_rd_credit_gate import axi_rd_credit_pkg::*; #(
  parameter bit HIGH_PERF  = 1'b1,
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 2,
  parameter int LINE_CAP   = 2,
  parameter int NC_CAP     = 4,
  parameter int DATA_CAP   = 4,
  parameter int IFETCH_CAP = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_sat,
  input  logic [NKIND-1:0]        req_vld,
  input  logic [NKIND*ADDR_W-1:0] req_addr,
  output logic [NKIND-1:0]        req_gnt,
  output logic                    m_arvalid,
  input  logic                    m_arready,
  output logic [ID_W-1:0]         m_arid,
  output logic [ADDR_W-1:0]       m_araddr,
  input  logic                    m_rvalid,
  input  logic                    m_rready,
  input  logic [ID_W-1:0]         m_rid,
  input  logic                    m_rlast
);
  localparam int NPOOL     = pool_count(HIGH_PERF);
  localparam int TOTAL_CAP = HIGH_PERF ? (LINE_CAP + NC_CAP + IFETCH_CAP)
                                       : (DATA_CAP + IFETCH_CAP);
  localparam int MAX_CAP   = (NC_CAP > DATA_CAP) ? NC_CAP : DATA_CAP;
  localparam int CNT_W     = $clog2(MAX_CAP + 1);
  localparam int SUM_W     = CNT_W + 2;

  function automatic int cap_of(input int p);
    if (HIGH_PERF) return (p == 0) ? LINE_CAP : ((p == 1) ? NC_CAP : IFETCH_CAP);
    return (p == 0) ? DATA_CAP : IFETCH_CAP;
  endfunction

  logic [NPOOL-1:0] pool_inc;
  logic [NPOOL-1:0] pool_dec;
  logic [NPOOL-1:0] pool_room;
  logic [CNT_W-1:0] pool_cnt [NPOOL];
  logic [NKIND-1:0] kind_room;
  logic             slot_free;
  logic             ar_hs;
  logic [ID_W-1:0]  ld_id;
  logic [ADDR_W-1:0] ld_addr;
  logic [SUM_W-1:0] total_out;

  // credit pools, one per ID in use
  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    localparam int PCAP = cap_of(p);
    assign pool_inc[p] = ar_hs && (m_arid == ID_W'(p));
    rd_credit_ctr #(.CAP(PCAP), .CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (pool_inc[p]),
      .dec  (pool_dec[p]),
      .cnt  (pool_cnt[p]),
      .room (pool_room[p])
    );
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    localparam int KP = kind_pool(HIGH_PERF, k);
    assign kind_room[k] = pool_room[KP];
  end

  rd_retire_map #(.NPOOL(NPOOL), .ID_W(ID_W)) u_retire (
    .rvalid(m_rvalid),
    .rready(m_rready),
    .rlast (m_rlast),
    .rid   (m_rid),
    .dec   (pool_dec)
  );

  rd_kind_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_free(slot_free),
    .wr_sat   (wr_sat),
    .req_vld  (req_vld),
    .kind_room(kind_room),
    .gnt      (req_gnt)
  );

  always_comb begin
    ld_id   = '0;
    ld_addr = '0;
    for (int k = 0; k < NKIND; k++) begin
      if (req_gnt[k]) begin
        ld_id   = ID_W'(kind_pool(HIGH_PERF, k));
        ld_addr = req_addr[k*ADDR_W +: ADDR_W];
      end
    end
  end

  rd_ar_slot #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req_gnt != '0),
    .load_id  (ld_id),
    .load_addr(ld_addr),
    .arready  (m_arready),
    .arvalid  (m_arvalid),
    .arid     (m_arid),
    .araddr   (m_araddr),
    .hs       (ar_hs),
    .free     (slot_free)
  );

  always_comb begin
    total_out = '0;
    for (int p = 0; p < NPOOL; p++) total_out += SUM_W'(pool_cnt[p]);
  end

  // R5
  total_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total_out <= SUM_W'(TOTAL_CAP));

  // R4
  arid_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (m_arid < ID_W'(NPOOL)));

endmodule

// File: tb/axi_rd_credit_gate_bench.sv
`timescale 1ns/1ps
module axi_rd_credit_gate_bench;
  localparam int AW = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic          wr_sat   [2];
  logic [2:0]    req_vld  [2];
  logic [3*AW-1:0] req_addr [2];
  logic [2:0]    req_gnt  [2];
  logic          arvalid  [2];
  logic          arready  [2];
  logic [IW-1:0] arid     [2];
  logic [AW-1:0] araddr   [2];
  logic          rvalid   [2];
  logic          rready   [2];
  logic          rlast    [2];
  logic [IW-1:0] rid      [2];

  axi_rd_credit_gate #(.HIGH_PERF(1'b1), .ADDR_W(AW), .ID_W(IW)) u_axi_rd_credit_gate (
    .clk(clk), .rst_n(rst_n), .wr_sat(wr_sat[0]), .req_vld(req_vld[0]),
    .req_addr(req_addr[0]), .req_gnt(req_gnt[0]), .m_arvalid(arvalid[0]),
    .m_arready(arready[0]), .m_arid(arid[0]), .m_araddr(araddr[0]),
    .m_rvalid(rvalid[0]), .m_rready(rready[0]), .m_rid(rid[0]), .m_rlast(rlast[0]));

  axi_rd_credit_gate #(.HIGH_PERF(1'b0), .ADDR_W(AW), .ID_W(IW)) u_axi_rd_credit_gate_ao (
    .clk(clk), .rst_n(rst_n), .wr_sat(wr_sat[1]), .req_vld(req_vld[1]),
    .req_addr(req_addr[1]), .req_gnt(req_gnt[1]), .m_arvalid(arvalid[1]),
    .m_arready(arready[1]), .m_arid(arid[1]), .m_araddr(araddr[1]),
    .m_rvalid(rvalid[1]), .m_rready(rready[1]), .m_rid(rid[1]), .m_rlast(rlast[1]));

  // reference model state (index 0: high-throughput, 1: compact)
  int          cnt   [2][3];
  bit          sfull [2];
  int          sid   [2];
  logic [AW-1:0] saddr [2];
  int          oq    [2][$];
  bit          granted [2][3];
  int          vectors = 0;
  int          miscompares = 0;
  string       tag = "R1";
  bit          run_en = 1'b0;

  function automatic int mpool(int m, int k);
    if (m == 0) return k;
    return (k == 2) ? 1 : 0;
  endfunction

  function automatic int mnpool(int m);
    return (m == 0) ? 3 : 2;
  endfunction

  function automatic int mcap(int m, int p);
    if (m == 0) return (p == 0) ? 2 : ((p == 1) ? 4 : 1);
    return (p == 0) ? 4 : 1;
  endfunction

  task automatic chk(int m, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s inst%0d %s actual=%0h expected=%0h at %0t", tag, m, what, act, exp, $time);
    end
  endtask

  task automatic step_model(int m);
    int win = -1;
    logic [2:0] eg = 3'b000;
    if (!sfull[m]) begin
      foreach (granted[0][j]) begin
        int k = (j == 0) ? 2 : j - 1;   // order: instruction, linefill, non-cacheable
        if (win < 0 && req_vld[m][k] && cnt[m][mpool(m, k)] < mcap(m, mpool(m, k))
            && (k == 2 || !wr_sat[m]))
          win = k;
      end
    end
    if (win >= 0) eg[win] = 1'b1;
    chk(m, "req_gnt", 64'(req_gnt[m]), 64'(eg));
    chk(m, "m_arvalid", 64'(arvalid[m]), 64'(sfull[m]));
    if (sfull[m]) begin
      chk(m, "m_arid", 64'(arid[m]), 64'(sid[m]));
      chk(m, "m_araddr", 64'(araddr[m]), 64'(saddr[m]));
    end
    // state after the coming edge
    if (rvalid[m] && rready[m] && rlast[m] && int'(rid[m]) < mnpool(m)) begin
      cnt[m][rid[m]]--;
      foreach (oq[m][i]) if (oq[m][i] == int'(rid[m])) begin oq[m].delete(i); break; end
    end
    if (sfull[m] && arready[m]) begin
      cnt[m][sid[m]]++;
      oq[m].push_back(sid[m]);
      sfull[m] = 1'b0;
    end else if (win >= 0) begin
      sfull[m] = 1'b1;
      sid[m]   = mpool(m, win);
      saddr[m] = req_addr[m][win*AW +: AW];
      granted[m][win] = 1'b1;
    end
  endtask

  always @(negedge clk) if (run_en) begin
    step_model(0);
    step_model(1);
  end

  task automatic drive(int m, logic [2:0] mask, int ardy, int rpct, int wpct);
    for (int k = 0; k < 3; k++) begin
      if (!mask[k]) begin
        req_vld[m][k] = 1'b0;
        granted[m][k] = 1'b0;
      end else if (granted[m][k] || !req_vld[m][k]) begin
        granted[m][k] = 1'b0;
        req_vld[m][k] = ($urandom_range(99) < 60);
        req_addr[m][k*AW +: AW] = $urandom;
      end
    end
    arready[m] = ($urandom_range(99) < ardy);
    wr_sat[m]  = ($urandom_range(99) < wpct);
    rready[m]  = ($urandom_range(99) < 90);
    rvalid[m]  = 1'b0;
    rlast[m]   = 1'b0;
    rid[m]     = '0;
    if ($urandom_range(99) < rpct) begin
      if ($urandom_range(9) == 0) begin
        // unused ID: R8 says no credit moves
        rvalid[m] = 1'b1;
        rid[m]    = IW'((m == 0) ? 3 : 2 + $urandom_range(1));
        rlast[m]  = $urandom_range(1);
      end else if (oq[m].size() > 0) begin
        rvalid[m] = 1'b1;
        rid[m]    = IW'(oq[m][$urandom_range(oq[m].size() - 1)]);
        rlast[m]  = ($urandom_range(3) != 0);
      end
    end
  endtask

  task automatic run_phase(string t, logic [2:0] mask, int ardy, int rpct, int wpct, int ncyc);
    tag = t;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk);
      #1;
      drive(0, mask, ardy, rpct, wpct);
      drive(1, mask, ardy, rpct, wpct);
      run_en = 1'b1;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired during %s", tag);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      wr_sat[m] = 1'b0; req_vld[m] = '0; req_addr[m] = '0; arready[m] = 1'b0;
      rvalid[m] = 1'b0; rready[m] = 1'b0; rlast[m] = 1'b0; rid[m] = '0;
      sfull[m] = 1'b0; sid[m] = 0; saddr[m] = '0;
      for (int k = 0; k < 3; k++) begin cnt[m][k] = 0; granted[m][k] = 1'b0; end
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(m, "R1 m_arvalid in reset", 64'(arvalid[m]), 64'(0));
      chk(m, "R1 req_gnt in reset", 64'(req_gnt[m]), 64'(0));
    end
    rst_n = 1'b1;
    run_phase("R1",  3'b000, 100,  0,   0,  3);
    run_phase("R2",  3'b001, 100,  0,   0,  20);
    run_phase("R8",  3'b001, 100, 60,   0, 100);
    run_phase("R8",  3'b000, 100, 90,   0,  60);
    run_phase("R3",  3'b010, 100,  0,   0,  25);
    run_phase("R8",  3'b000, 100, 90,   0,  60);
    run_phase("R4",  3'b100, 100,  0,   0,  12);
    run_phase("R4",  3'b100, 100, 50,   0,  60);
    run_phase("R7",  3'b111, 100, 30,   0, 200);
    run_phase("R6",  3'b111, 100, 30, 100,  80);
    run_phase("R6",  3'b111,  70, 40,  50, 300);
    run_phase("R9",  3'b111,  30, 40,   0, 300);
    run_phase("R5",  3'b111, 100,  5,   0, 100);
    run_phase("R10", 3'b111, 100, 70,   0, 400);
    run_phase("R8",  3'b000, 100, 90,   0,  80);
    @(posedge clk);
    run_en = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule